// File: doc/BRIEF.md
# Fs-bit message transmitter for D4 superframes

This block places a 36-bit maintenance message onto the Fs bit positions of a T1 transmit stream framed in 12-frame superframes. The message is held as six 6-bit bytes. At the start of each superframe the block fetches one byte and sends its six bits in the six Fs slots of that superframe, bit 0 first. After six superframes the whole message has gone out and the cycle repeats. When insertion is turned off, the framer's own Fs pattern passes through unchanged.

There are two message banks. One bank is being sent while the host fills the other through a write port that selects a bank and has no address. An internal pointer places each accepted byte in the next location. After the sixth byte the filled bank is marked pending. The sender moves to a pending bank only at a message boundary. If no bank is pending, it sends the current bank again. A status output names the bank that the host may fill next.

The write port uses valid/ready. A beat is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls after the sixth byte and stays low until the sender takes the pending bank, so a filled message is never overwritten. An accepted beat aimed at the bank that is being sent is dropped.

Top module: `fsdl_tx`

## Requirements
- R1: While `rst` is high on a clock edge, the block selects bank 0 for sending and clears the write pointer. After reset, `nxt_free` is 1, `wr_ready` is 1, and `fs_out` is 0 with `mode_en` high until the first superframe start.
- R2: With `mode_en` low, `fs_out` equals `fs_in` in the same cycle.
- R3: With `mode_en` high, the six `fs_slot` cycles that follow a `sf_start` carry bits 0, 1, 2, 3, 4 and 5 of the fetched byte, in that order, on `fs_out`.
- R4: Each `sf_start` fetches the next byte of the sending bank, in the order location 0 to location 5, and wraps to location 0 after location 5.
- R5: The first accepted write after reset, or after a bank has been filled, goes to location 0. Each further accepted write to the free bank goes to the next location. The sixth write marks that bank pending and returns the pointer to location 0.
- R6: `wr_ready` is low from the cycle after the sixth write until the pending bank is taken for sending, and high at all other times.
- R7: An accepted write whose `wr_buf` equals the bank being sent changes neither the stored message nor the write pointer.
- R8: The sending bank changes only at a `sf_start` that fetches location 0, and only when the other bank is pending. Otherwise the current bank is sent again.
- R9: `nxt_free` toggles when the sender takes the pending bank, and it always names the bank that is not being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_en | input | 1 | 1: replace Fs bits with message bits; 0: pass `fs_in` through |
| sf_start | input | 1 | One-cycle strobe at the start of each superframe |
| fs_slot | input | 1 | One-cycle strobe for each Fs bit slot |
| fs_in | input | 1 | Normal Fs pattern bit from the framer |
| fs_out | output | 1 | Fs bit to transmit |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Host write beat may be accepted |
| wr_buf | input | 1 | Target bank of the write beat |
| wr_data | input | BYTE_W | Message byte to store |
| nxt_free | output | 1 | Bank the host may fill next |

## Verification
The hardest case to reach from the ports is a bank that becomes pending in the middle of a message. A switch at that point would be wrong, and the error shows only as a mixed message several superframes later. The bench fills half the free bank, runs two superframes, and finishes the fill. It then confirms that the remaining four bytes still come from the old bank and that the new message starts cleanly at the next boundary. Dropped writes to the sending bank are exposed the same way: the old message is sent again unchanged, and the next real fill lands at location 0.

// File: rtl/fsdl_pkg.sv
package fsdl_pkg;
  // Identity of a message bank
  typedef enum logic {
    BANK0 = 1'b0,
    BANK1 = 1'b1
  } bank_e;
endpackage

// File: rtl/fsdl_store.sv
module fsdl_store #(
  parameter int MSG_BYTES = 6,
  parameter int BYTE_W    = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_valid,
  input  logic                         wr_buf,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic                         wr_ready,
  input  logic                         tx_sel,
  input  logic                         take,
  input  logic                         rd_buf,
  input  logic [$clog2(MSG_BYTES)-1:0] rd_idx,
  output logic [BYTE_W-1:0]            rd_data,
  output logic                         pend
);
  localparam int IDX_W = $clog2(MSG_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(MSG_BYTES - 1);

  logic [IDX_W-1:0] wr_ptr;
  logic             hit;
  logic [1:0][BYTE_W-1:0] bank_q;

  assign wr_ready = !pend;
  // a beat lands only in the bank that is not on the line
  assign hit = wr_valid && wr_ready && (wr_buf != tx_sel);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [BYTE_W-1:0] cells [MSG_BYTES];
    always_ff @(posedge clk) begin
      if (hit && (wr_buf == 1'(b))) cells[wr_ptr] <= wr_data;
    end
    assign bank_q[b] = cells[rd_idx];
  end

  assign rd_data = bank_q[rd_buf];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      pend   <= 1'b0;
    end else begin
      if (take) pend <= 1'b0;
      if (hit) begin
        if (wr_ptr == LAST) begin
          wr_ptr <= '0;
          pend   <= 1'b1;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
        end
      end
    end
  end

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_buf == tx_sel) |=> $stable(wr_ptr));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> (wr_ptr == '0 && $past(wr_ptr) == LAST));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> ($stable(wr_ptr) && pend));

  // R8
  take_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !pend);
endmodule

// File: rtl/fsdl_seq.sv
module fsdl_seq
  import fsdl_pkg::*;
#(
  parameter int MSG_BYTES = 6,
  parameter int BYTE_W    = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sf_start,
  input  logic                         fs_slot,
  input  logic                         pend,
  input  logic [BYTE_W-1:0]            rd_data,
  output logic                         tx_sel,
  output logic                         rd_buf,
  output logic [$clog2(MSG_BYTES)-1:0] rd_idx,
  output logic                         take,
  output logic                         msg_bit
);
  localparam int IDX_W = $clog2(MSG_BYTES);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(MSG_BYTES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BYTE_W - 1);

  bank_e             tx_q;
  logic [IDX_W-1:0]  byte_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] cur_byte;

  // a pending bank is taken only at a message boundary
  assign take    = sf_start && (byte_idx == '0) && pend;
  assign tx_sel  = tx_q;
  assign rd_buf  = take ? ~tx_q : tx_q;
  assign rd_idx  = byte_idx;
  assign msg_bit = cur_byte[bit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q     <= BANK0;
      byte_idx <= '0;
      bit_idx  <= '0;
      cur_byte <= '0;
    end else if (sf_start) begin
      cur_byte <= rd_data;
      bit_idx  <= '0;
      byte_idx <= (byte_idx == LAST_BYTE) ? '0 : byte_idx + 1'b1;
      if (take) tx_q <= bank_e'(~tx_q);
    end else if (fs_slot) begin
      bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
    end
  end

  // R3
  bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST_BIT);

  // R4
  sf_bit_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sf_start |=> (bit_idx == '0));

  // R8
  sel_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_q) |-> ($past(sf_start) && $past(byte_idx) == '0 && $past(pend)));
endmodule

// File: rtl/fsdl_tx.sv
module fsdl_tx #(
  parameter int MSG_BYTES = 6,
  parameter int BYTE_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_en,
  input  logic              sf_start,
  input  logic              fs_slot,
  input  logic              fs_in,
  output logic              fs_out,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_buf,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              nxt_free
);
  localparam int IDX_W = $clog2(MSG_BYTES);

  logic              tx_sel, rd_buf, take, pend, msg_bit;
  logic [IDX_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] rd_data;

  fsdl_store #(.MSG_BYTES(MSG_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_buf(wr_buf), .wr_data(wr_data), .wr_ready(wr_ready),
    .tx_sel(tx_sel), .take(take), .rd_buf(rd_buf), .rd_idx(rd_idx),
    .rd_data(rd_data), .pend(pend)
  );

  fsdl_seq #(.MSG_BYTES(MSG_BYTES), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .sf_start(sf_start), .fs_slot(fs_slot),
    .pend(pend), .rd_data(rd_data), .tx_sel(tx_sel), .rd_buf(rd_buf),
    .rd_idx(rd_idx), .take(take), .msg_bit(msg_bit)
  );

  assign fs_out   = mode_en ? msg_bit : fs_in;
  assign nxt_free = ~tx_sel;

  // R9
  free_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (nxt_free != $past(nxt_free)));
endmodule

// File: tb/fsdl_tx_bench.sv
module fsdl_tx_bench;
  logic       clk = 1'b0;
  logic       rst, mode_en, sf_start, fs_slot, fs_in, wr_valid, wr_buf;
  logic [5:0] wr_data;
  logic       fs_out, wr_ready, nxt_free;
  int         vectors = 0;
  int         fails = 0;
  logic [5:0] msg_a [6];
  logic [5:0] msg_b [6];

  always #5 clk = ~clk;

  fsdl_tx u_fsdl_tx (
    .clk(clk), .rst(rst), .mode_en(mode_en), .sf_start(sf_start),
    .fs_slot(fs_slot), .fs_in(fs_in), .fs_out(fs_out), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_buf(wr_buf), .wr_data(wr_data), .nxt_free(nxt_free)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic b, input logic [5:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_buf = b; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_sf(output logic [5:0] got);
    @(negedge clk); sf_start = 1'b1;
    @(negedge clk); sf_start = 1'b0;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk); fs_slot = 1'b1;
      #3 got[s] = fs_out;
      @(negedge clk); fs_slot = 1'b0;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    mode_en = 1'b1;
    #3;
    chk("R1", "nxt_free after reset", 8'(nxt_free), 8'd1);
    chk("R1", "wr_ready after reset", 8'(wr_ready), 8'd1);
    chk("R1", "fs_out before first superframe", 8'(fs_out), 8'd0);
  endtask

  task automatic t_bypass;
    mode_en = 1'b0;
    @(negedge clk); fs_slot = 1'b1; fs_in = 1'b1;
    #3 chk("R2", "bypass high", 8'(fs_out), 8'd1);
    @(negedge clk); fs_in = 1'b0;
    #3 chk("R2", "bypass low", 8'(fs_out), 8'd0);
    @(negedge clk); fs_slot = 1'b0;
  endtask

  task automatic t_fill_first;
    for (int k = 0; k < 6; k++) write_byte(1'b1, msg_a[k]);
    #3;
    chk("R6", "ready low once bank 1 is full", 8'(wr_ready), 8'd0);
    chk("R9", "free bank unchanged before take", 8'(nxt_free), 8'd1);
  endtask

  task automatic t_send_first;
    logic [5:0] got;
    mode_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      run_sf(got);
      chk("R3", $sformatf("message A byte %0d", k), 8'(got), 8'(msg_a[k]));
      if (k == 0) begin
        chk("R9", "free bank toggled on take", 8'(nxt_free), 8'd0);
        chk("R6", "ready back after take", 8'(wr_ready), 8'd1);
      end
      if (k == 1) begin
        // R7: beats aimed at the bank being sent
        for (int j = 0; j < 3; j++) write_byte(1'b1, 6'h2A);
        #3 chk("R7", "ready unaffected by dropped writes", 8'(wr_ready), 8'd1);
      end
    end
  endtask

  task automatic t_repeat;
    logic [5:0] got;
    for (int k = 0; k < 6; k++) begin
      run_sf(got);
      chk("R8", $sformatf("repeat of A byte %0d (R7 intact)", k), 8'(got), 8'(msg_a[k]));
    end
    chk("R9", "no toggle without pending bank", 8'(nxt_free), 8'd0);
  endtask

  task automatic t_midway_fill;
    logic [5:0] got;
    for (int k = 0; k < 3; k++) write_byte(1'b0, msg_b[k]);
    #3 chk("R6", "ready high with partial fill", 8'(wr_ready), 8'd1);
    for (int k = 0; k < 2; k++) begin
      run_sf(got);
      chk("R4", $sformatf("A byte %0d during partial fill", k), 8'(got), 8'(msg_a[k]));
    end
    for (int k = 3; k < 6; k++) write_byte(1'b0, msg_b[k]);
    #3 chk("R6", "ready low once bank 0 is full", 8'(wr_ready), 8'd0);
    for (int k = 2; k < 6; k++) begin
      run_sf(got);
      chk("R8", $sformatf("no switch mid-message, A byte %0d", k), 8'(got), 8'(msg_a[k]));
    end
    chk("R9", "free bank held until boundary", 8'(nxt_free), 8'd0);
  endtask

  task automatic t_send_second;
    logic [5:0] got;
    for (int k = 0; k < 6; k++) begin
      run_sf(got);
      chk("R5", $sformatf("message B byte %0d", k), 8'(got), 8'(msg_b[k]));
      if (k == 0) chk("R9", "free bank toggled back", 8'(nxt_free), 8'd1);
    end
    chk("R6", "ready after second take", 8'(wr_ready), 8'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    msg_a[0] = 6'b011100; msg_a[1] = 6'b111100; msg_a[2] = 6'b101101;
    msg_a[3] = 6'b100110; msg_a[4] = 6'b010110; msg_a[5] = 6'b011001;
    msg_b[0] = 6'b011100; msg_b[1] = 6'b011100; msg_b[2] = 6'b010010;
    msg_b[3] = 6'b101001; msg_b[4] = 6'b101000; msg_b[5] = 6'b010110;
    rst = 1'b1; mode_en = 1'b0; sf_start = 1'b0; fs_slot = 1'b0; fs_in = 1'b0;
    wr_valid = 1'b0; wr_buf = 1'b0; wr_data = '0;
    t_reset();
    t_bypass();
    t_fill_first();
    t_send_first();
    t_repeat();
    t_midway_fill();
    t_send_second();
    t_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule